// File: doc/BRIEF.md
# Byte-Framed Serial Control Decoder

This block receives control bytes for an audio processor over a three-wire serial link: an active-low frame enable, a serial clock and a data line. All three wires are brought into a faster system clock through two-flop synchronisers, and edges are found on the synchronised copies. While the frame enable is low, each rising serial-clock edge shifts one data bit into an eight-bit register, most significant bit first. When the enable returns high, the byte is accepted only if the frame held exactly eight serial-clock edges. A frame with any other count is dropped without a trace, so a spike on the clock line cannot store a wrong setting.

An accepted byte is decoded by value into one of several registered control words: master volume, bass, treble, four speaker attenuators, input selection and a secondary mute. A combined output-mute flag is raised when all four speaker attenuators are muted and the secondary mute is also set.

Top module: `serctl_decoder`

## Requirements
- R1: While the enable is low, each rising serial-clock edge samples the data line into the shift register, most significant bit first.
- R2: A rising enable edge commits the shifted byte only when exactly 8 serial-clock edges were counted in that frame.
- R3: A frame with fewer or more than 8 edges (counter saturates at 9) is discarded, and every control output keeps its value.
- R4: The edge counter clears on the falling enable edge. A serial-clock edge in the same system cycle as that fall is counted as the first bit. A serial-clock edge in the same system cycle as the rising enable edge is not counted.
- R5: A byte 0..72 sets the volume code to that value. Code 0 is +11.25 dB, and each step adds 1.25 dB of attenuation down to -78.75 dB at 72.
- R6: A byte 73..93 sets the bass code to byte-73. Code 0 is -20 dB, 10 is 0 dB and 20 is +20 dB, in 2 dB steps.
- R7: A byte 94..108 sets the treble code to byte-94. Code 0 is -14 dB, 7 is 0 dB and 14 is +14 dB.
- R8: A byte 109..112 sets the input select to byte-109. Byte 113 sets the secondary mute and byte 114 clears it. Bytes 115..127 change nothing.
- R9: A byte with bit 7 set addresses a speaker attenuator through bits 6:5 (0 left front, 1 right front, 2 left rear, 3 right rear). Bits 4:0 give the attenuation in 1.25 dB steps, and the value 31 means muted.
- R10: The output mute is high exactly when the secondary mute is set and all four speaker codes are 31.
- R11: After reset, volume is 72, bass is 10, treble is 7, every speaker is 31, the input select is 0 and the secondary mute is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en_n | input | 1 | Frame enable, active low, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| vol_code | output | 7 | Volume attenuation code |
| bass_code | output | 5 | Bass code |
| treble_code | output | 4 | Treble code |
| spk_lf | output | 5 | Left front attenuator code |
| spk_rf | output | 5 | Right front attenuator code |
| spk_lr | output | 5 | Left rear attenuator code |
| spk_rr | output | 5 | Right rear attenuator code |
| in_sel | output | 2 | Input select |
| sec_mute | output | 1 | Secondary mute |
| out_mute | output | 1 | Combined output mute |

## Verification
The frame boundary and a serial-clock edge can land in the same system cycle, because the enable and clock wires pass through synchronisers of equal depth. The bench provokes this in two ways. In one frame it drops the enable and raises the clock at the same instant, then sends seven more edges; the frame must commit, which shows the coincident edge was counted as bit one. In another frame it sends eight edges and then raises the clock and the enable together; this frame must commit the original byte, which shows the extra edge was neither counted nor shifted in.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(BYTE_W + 1);

  localparam int N_SPK  = 4;
  localparam int VOL_W  = 7;
  localparam int BASS_W = 5;
  localparam int TRB_W  = 4;
  localparam int SPK_W  = 5;
  localparam int SEL_W  = 2;

  localparam logic [6:0] VOL_LAST   = 7'd72;
  localparam logic [6:0] BASS_BASE  = 7'd73;
  localparam logic [6:0] BASS_LAST  = 7'd93;
  localparam logic [6:0] TRB_BASE   = 7'd94;
  localparam logic [6:0] TRB_LAST   = 7'd108;
  localparam logic [6:0] SEL_BASE   = 7'd109;
  localparam logic [6:0] SEL_LAST   = 7'd112;
  localparam logic [6:0] SMUTE_ON   = 7'd113;
  localparam logic [6:0] SMUTE_OFF  = 7'd114;

  localparam logic [VOL_W-1:0]  VOL_RST  = 7'd72;
  localparam logic [BASS_W-1:0] BASS_RST = 5'd10;
  localparam logic [TRB_W-1:0]  TRB_RST  = 4'd7;
  localparam logic [SPK_W-1:0]  SPK_MUTE = 5'd31;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/serctl_frame_rx.sv
module serctl_frame_rx
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n_s,
  input  logic              sclk_s,
  input  logic              sdat_s,
  output logic              commit_vld,
  output logic [BYTE_W-1:0] commit_byte,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic              en_d_q, sclk_d_q;
  logic [BYTE_W-1:0] shift_q, shift_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt, cnt_base;
  logic              vld_q, vld_nxt;
  logic [BYTE_W-1:0] byte_q, byte_nxt;
  logic              en_fall, en_rise, sclk_rise;

  assign en_fall   = !en_n_s && en_d_q;
  assign en_rise   = en_n_s && !en_d_q;
  assign sclk_rise = sclk_s && !sclk_d_q;

  always_comb begin
    shift_nxt = shift_q;
    cnt_base  = en_fall ? '0 : cnt_q;
    cnt_nxt   = cnt_base;
    if (!en_n_s && sclk_rise) begin
      shift_nxt = {shift_q[BYTE_W-2:0], sdat_s};
      cnt_nxt   = (cnt_base == CNT_SAT) ? CNT_SAT : cnt_base + 1'b1;
    end
    vld_nxt  = en_rise && (cnt_q == CNT_FULL);
    byte_nxt = vld_nxt ? shift_q : byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d_q   <= 1'b1;
      sclk_d_q <= 1'b0;
      shift_q  <= '0;
      cnt_q    <= '0;
      vld_q    <= 1'b0;
      byte_q   <= '0;
    end else begin
      en_d_q   <= en_n_s;
      sclk_d_q <= sclk_s;
      shift_q  <= shift_nxt;
      cnt_q    <= cnt_nxt;
      vld_q    <= vld_nxt;
      byte_q   <= byte_nxt;
    end
  end

  assign commit_vld  = vld_q;
  assign commit_byte = byte_q;
  assign bit_cnt     = cnt_q;
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs
  import serctl_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_vld,
  input  logic [BYTE_W-1:0]      commit_byte,
  output logic [VOL_W-1:0]       vol_q,
  output logic [BASS_W-1:0]      bass_q,
  output logic [TRB_W-1:0]       trb_q,
  output logic [N_SPK*SPK_W-1:0] spk_q,
  output logic [SEL_W-1:0]       sel_q,
  output logic                   smute_q
);
  logic [6:0]        low7;
  logic              vol_en, bass_en, trb_en, sel_en, smute_en;
  logic [VOL_W-1:0]  vol_nxt;
  logic [BASS_W-1:0] bass_nxt;
  logic [TRB_W-1:0]  trb_nxt;
  logic [SEL_W-1:0]  sel_nxt;
  logic              smute_nxt;
  logic [N_SPK-1:0]  spk_en;
  logic [SPK_W-1:0]  spk_nxt;

  assign low7 = commit_byte[6:0];

  always_comb begin
    vol_en    = 1'b0;
    bass_en   = 1'b0;
    trb_en    = 1'b0;
    sel_en    = 1'b0;
    smute_en  = 1'b0;
    spk_en    = '0;
    vol_nxt   = low7;
    bass_nxt  = BASS_W'(low7 - BASS_BASE);
    trb_nxt   = TRB_W'(low7 - TRB_BASE);
    sel_nxt   = SEL_W'(low7 - SEL_BASE);
    smute_nxt = (low7 == SMUTE_ON);
    spk_nxt   = commit_byte[SPK_W-1:0];
    if (commit_vld) begin
      if (commit_byte[7]) begin
        spk_en[commit_byte[6:5]] = 1'b1;
      end else if (low7 <= VOL_LAST) begin
        vol_en = 1'b1;
      end else if (low7 <= BASS_LAST) begin
        bass_en = 1'b1;
      end else if (low7 <= TRB_LAST) begin
        trb_en = 1'b1;
      end else if (low7 <= SEL_LAST) begin
        sel_en = 1'b1;
      end else if ((low7 == SMUTE_ON) || (low7 == SMUTE_OFF)) begin
        smute_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_q   <= VOL_RST;
      bass_q  <= BASS_RST;
      trb_q   <= TRB_RST;
      sel_q   <= '0;
      smute_q <= 1'b1;
    end else begin
      if (vol_en)   vol_q   <= vol_nxt;
      if (bass_en)  bass_q  <= bass_nxt;
      if (trb_en)   trb_q   <= trb_nxt;
      if (sel_en)   sel_q   <= sel_nxt;
      if (smute_en) smute_q <= smute_nxt;
    end
  end

  for (genvar g = 0; g < N_SPK; g++) begin : g_spk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        spk_q[g*SPK_W +: SPK_W] <= SPK_MUTE;
      end else if (spk_en[g]) begin
        spk_q[g*SPK_W +: SPK_W] <= spk_nxt;
      end
    end
  end
endmodule

// File: rtl/serctl_decoder.sv
module serctl_decoder
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [VOL_W-1:0]  vol_code,
  output logic [BASS_W-1:0] bass_code,
  output logic [TRB_W-1:0]  treble_code,
  output logic [SPK_W-1:0]  spk_lf,
  output logic [SPK_W-1:0]  spk_rf,
  output logic [SPK_W-1:0]  spk_lr,
  output logic [SPK_W-1:0]  spk_rr,
  output logic [SEL_W-1:0]  in_sel,
  output logic              sec_mute,
  output logic              out_mute
);
  logic                   rst_meta_q, rst_sync_n;
  logic [2:0]             pins_s;
  logic                   commit_vld;
  logic [BYTE_W-1:0]      commit_byte;
  logic [CNT_W-1:0]       bit_cnt;
  logic [N_SPK*SPK_W-1:0] spk_all;
  logic [N_SPK-1:0]       spk_is_mute;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  serctl_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async ({ser_dat, ser_clk, ser_en_n}),
    .d_sync  (pins_s)
  );

  serctl_frame_rx u_rx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .en_n_s      (pins_s[0]),
    .sclk_s      (pins_s[1]),
    .sdat_s      (pins_s[2]),
    .commit_vld  (commit_vld),
    .commit_byte (commit_byte),
    .bit_cnt     (bit_cnt)
  );

  serctl_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .commit_vld  (commit_vld),
    .commit_byte (commit_byte),
    .vol_q       (vol_code),
    .bass_q      (bass_code),
    .trb_q       (treble_code),
    .spk_q       (spk_all),
    .sel_q       (in_sel),
    .smute_q     (sec_mute)
  );

  for (genvar g = 0; g < N_SPK; g++) begin : g_mute
    assign spk_is_mute[g] = (spk_all[g*SPK_W +: SPK_W] == SPK_MUTE);
  end

  assign spk_lf   = spk_all[0*SPK_W +: SPK_W];
  assign spk_rf   = spk_all[1*SPK_W +: SPK_W];
  assign spk_lr   = spk_all[2*SPK_W +: SPK_W];
  assign spk_rr   = spk_all[3*SPK_W +: SPK_W];
  assign out_mute = sec_mute && (&spk_is_mute);
endmodule

// File: rtl/serctl_decoder_chk.sv
module serctl_decoder_chk
  import serctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              commit_vld,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [VOL_W-1:0]  vol_code,
  input logic [BASS_W-1:0] bass_code,
  input logic [TRB_W-1:0]  treble_code,
  input logic [SPK_W-1:0]  spk_lf,
  input logic [SPK_W-1:0]  spk_rf,
  input logic [SPK_W-1:0]  spk_lr,
  input logic [SPK_W-1:0]  spk_rr,
  input logic [SEL_W-1:0]  in_sel,
  input logic              sec_mute,
  input logic              out_mute
);
  assert_commit_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |-> ($past(bit_cnt) == CNT_FULL));

  assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_SAT);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_vld |=> $stable({vol_code, bass_code, treble_code, spk_lf, spk_rf,
                             spk_lr, spk_rr, in_sel, sec_mute}));

  assert_vol_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vol_code <= VOL_LAST);

  assert_bass_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bass_code <= 5'd20);

  assert_treble_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    treble_code <= 4'd14);

  assert_mute_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_mute) |-> $past(commit_vld));
endmodule

bind serctl_decoder serctl_decoder_chk u_chk (.*);

// File: tb/serctl_decoder_tb.sv
module serctl_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en_n = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic [6:0] vol_code;
  logic [4:0] bass_code;
  logic [3:0] treble_code;
  logic [4:0] spk_lf, spk_rf, spk_lr, spk_rr;
  logic [1:0] in_sel;
  logic sec_mute, out_mute;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [6:0] m_vol;
  logic [4:0] m_bass;
  logic [3:0] m_trb;
  logic [4:0] m_spk [4];
  logic [1:0] m_sel;
  logic m_smute;

  always #4 clk = ~clk;

  serctl_decoder u_dut (.*);

  localparam int NV = 18;
  localparam logic [11:0] VEC [NV] = '{
    {8'h00, 4'd8}, {8'h48, 4'd8}, {8'h12, 4'd8}, {8'h10, 4'd7},
    {8'h05, 4'd9}, {8'h33, 4'd0}, {8'h49, 4'd8}, {8'h5D, 4'd8},
    {8'h5E, 4'd8}, {8'h6C, 4'd8}, {8'h6F, 4'd8}, {8'h80, 4'd8},
    {8'hBF, 4'd8}, {8'hC5, 4'd8}, {8'hFF, 4'd8}, {8'h72, 4'd8},
    {8'h75, 4'd8}, {8'h71, 4'd8}
  };

  function automatic string req_of(input logic [7:0] b, input int n);
    if (n != 8)       return "R3";
    if (b[7])         return "R9";
    if (b[6:0] <= 72) return "R5";
    if (b[6:0] <= 93) return "R6";
    if (b[6:0] <= 108) return "R7";
    return "R8";
  endfunction

  task automatic model_reset();
    m_vol = 7'd72; m_bass = 5'd10; m_trb = 4'd7; m_sel = 2'd0; m_smute = 1'b1;
    for (int i = 0; i < 4; i++) m_spk[i] = 5'd31;
  endtask

  task automatic model_apply(input logic [7:0] b);
    int v;
    v = int'(b[6:0]);
    if (b[7]) m_spk[b[6:5]] = b[4:0];
    else if (v <= 72)  m_vol = 7'(v);
    else if (v <= 93)  m_bass = 5'(v - 73);
    else if (v <= 108) m_trb = 4'(v - 94);
    else if (v <= 112) m_sel = 2'(v - 109);
    else if (v == 113) m_smute = 1'b1;
    else if (v == 114) m_smute = 1'b0;
  endtask

  function automatic logic [39:0] exp_word();
    logic mm;
    mm = m_smute && (m_spk[0] == 31) && (m_spk[1] == 31) && (m_spk[2] == 31) && (m_spk[3] == 31);
    return {m_vol, m_bass, m_trb, m_spk[0], m_spk[1], m_spk[2], m_spk[3], m_sel, m_smute, mm};
  endfunction

  task automatic check_all(input string req, input string what);
    logic [39:0] act, exp;
    act = {vol_code, bass_code, treble_code, spk_lf, spk_rf, spk_lr, spk_rr, in_sel, sec_mute, out_mute};
    exp = exp_word();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input int n);
    ser_en_n = 1'b0;
    wait_cyc(8);
    for (int i = 0; i < n; i++) begin
      ser_dat = (i < 8) ? b[7-i] : 1'b0;
      wait_cyc(8);
      ser_clk = 1'b1;
      wait_cyc(8);
      ser_clk = 1'b0;
    end
    wait_cyc(8);
    ser_en_n = 1'b1;
    wait_cyc(16);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(6);
    check_all("R11", "reset values");

    // table walk: R1 MSB-first (0x48 vs 0x12), R2 commits, R3 drops, R5..R9, R10
    for (int k = 0; k < NV; k++) begin
      logic [7:0] b;
      int n;
      b = VEC[k][11:4];
      n = int'(VEC[k][3:0]);
      send_frame(b, n);
      if (n == 8) model_apply(b);
      check_all(req_of(b, n), $sformatf("byte %h edges %0d", b, n));
    end

    // R10: all speakers muted plus secondary mute
    send_frame(8'h9F, 8); model_apply(8'h9F);
    send_frame(8'hDF, 8); model_apply(8'hDF);
    check_all("R10", "full mute set");
    send_frame(8'h72, 8); model_apply(8'h72);
    check_all("R10", "secondary mute cleared");

    // R4: clock edge in the same cycle as the enable fall counts as bit one
    begin
      logic [7:0] b;
      b = 8'h2A;
      ser_dat = b[7];
      ser_en_n = 1'b0;
      ser_clk = 1'b1;
      wait_cyc(8);
      ser_clk = 1'b0;
      for (int i = 1; i < 8; i++) begin
        ser_dat = b[7-i];
        wait_cyc(8);
        ser_clk = 1'b1;
        wait_cyc(8);
        ser_clk = 1'b0;
      end
      wait_cyc(8);
      ser_en_n = 1'b1;
      wait_cyc(16);
      model_apply(b);
      check_all("R4", "edge coincident with enable fall");
    end

    // R4: edge in the same cycle as the enable rise is not counted
    begin
      logic [7:0] b;
      b = 8'h17;
      ser_en_n = 1'b0;
      wait_cyc(8);
      for (int i = 0; i < 8; i++) begin
        ser_dat = b[7-i];
        wait_cyc(8);
        ser_clk = 1'b1;
        wait_cyc(8);
        ser_clk = 1'b0;
      end
      ser_dat = 1'b1;
      wait_cyc(8);
      ser_clk = 1'b1;
      ser_en_n = 1'b1;
      wait_cyc(8);
      ser_clk = 1'b0;
      wait_cyc(16);
      model_apply(b);
      check_all("R4", "edge coincident with enable rise");
    end

    // R3: long frame of 12 edges dropped
    send_frame(8'h01, 12);
    check_all("R3", "twelve edges dropped");

    // R11: reset mid-run restores defaults
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    model_reset();
    wait_cyc(6);
    check_all("R11", "second reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule